// File: doc/BRIEF.md
# Prescaled Timer with Interval and PWM Modes

This block is an 8-bit up-counter. A programmable prescaler divides the system clock, and the counter advances once per prescaled tick. It has two modes. In interval mode the counter restarts from zero on the tick after it reaches the compare value. Each such restart flips the output pin, so the output is a square wave whose half-period is set by software. In PWM mode the counter runs freely and wraps at the top of the selected resolution. The output stays high while the compare value is above the counter, which gives a pulse whose width is set by software.

Software drives a small register write port with three targets: control, compare data and prescaler select. The counter can be read back directly. A compare match raises a pending flag, and so does a counter wrap. Each flag is ANDed with its own enable to form an interrupt request. In PWM mode the comparator reads a shadow copy of the data register, and that copy is reloaded only at wrap. A new duty value therefore never cuts into a period that has already started.

Top module: `pwmt_top`

## Requirements
- R1: After reset the counter reads 0, and the output, both pending flags and both interrupt requests are 0.
- R2: With prescaler select S (register address 2, bits 3:0), the counter advances once every S+1 clock cycles.
- R3: In PWM mode (control bit 0 = 1) a compare match does not clear the counter. The period is (TOP+1)*(S+1) clock cycles, where TOP is the wrap value for the selected resolution.
- R4: In PWM mode the output is high exactly while the masked compare value is greater than the masked counter, and low otherwise. Over one period this gives (D and TOP)*(S+1) high cycles.
- R5: Control bits 2:1 select the resolution: 00 and 11 give 8 bits (TOP=0xFF), 01 gives 7 bits (TOP=0x7F), 10 gives 6 bits (TOP=0x3F). Only the low bits of the counter and the data take part in the compare.
- R6: In PWM mode the comparator's shadow register reloads from the data register (address 1) only at counter wrap or on a counter clear. A data write in mid-period therefore leaves the current period unchanged.
- R7: In interval mode (control bit 0 = 0) the counter goes to 0 on the tick after it equals the compare value, giving a period of (D+1)*(S+1) cycles. The output toggles at each such match.
- R8: A match (a tick while the masked counter equals the masked compare value) sets the match pending flag. The match interrupt request equals that flag ANDed with control bit 4.
- R9: A wrap from TOP to 0 sets the overflow pending flag. The overflow interrupt request equals that flag ANDed with control bit 5.
- R10: A control write with bit 6 = 1 clears the match flag, and a control write with bit 7 = 1 clears the overflow flag. If a new event occurs in the same cycle, the event wins.
- R11: A control write with bit 3 = 1 sets the counter and the prescaler to 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 data, 2 prescaler |
| wr_data | input | 8 | Write data |
| cnt_value | output | 8 | Current counter value |
| pwm_out | output | 1 | Timer output pin |
| match_pend | output | 1 | Match pending flag |
| ovf_pend | output | 1 | Overflow pending flag |
| irq_match | output | 1 | Match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The prescaler check assumes that the select field stays unchanged across a tick, unless a register write changes it. The counter checks assume that a mode or resolution change arrives together with a counter clear. The stimulus follows this rule: for each configuration it writes the prescaler and the data registers first, then writes the control register with the clear bit set. Mid-run writes touch only the data register, or the control register with its current fields kept.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    RES_8  = 2'b00,
    RES_7  = 2'b01,
    RES_6  = 2'b10,
    RES_8B = 2'b11
  } res_e;

  // wrap value for a resolution code
  function automatic logic [CNT_W-1:0] top_value(res_e r);
    case (r)
      RES_7:   return 8'h7F;
      RES_6:   return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  // next counter value when free running
  function automatic logic [CNT_W-1:0] step_count(logic [CNT_W-1:0] c,
                                                  logic [CNT_W-1:0] top);
    return ((c & top) == top) ? '0 : ((c & top) + 1'b1);
  endfunction
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [PSC_W-1:0] sel,
  output logic             tick
);
  logic [PSC_W-1:0] div_q;

  assign tick = (div_q == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (clr)     div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && !clr) |=> (!tick || !$stable(sel)));
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             pwm_mode,
  input  res_e             res,
  input  logic [CNT_W-1:0] data,
  output logic [CNT_W-1:0] cnt,
  output logic             match_evt,
  output logic             ovf_evt,
  output logic             out
);
  logic [CNT_W-1:0] cnt_q, shadow_q, top_v, cnt_m, cmp_m;
  logic             hit, at_top, tog_q;

  always_comb begin
    top_v     = top_value(res);
    cnt_m     = cnt_q & top_v;
    cmp_m     = shadow_q & top_v;
    hit       = (cnt_m == cmp_m);
    at_top    = (cnt_m == top_v);
    match_evt = tick & hit & ~clr;
    ovf_evt   = tick & at_top & ~clr & (pwm_mode | ~hit);
    out       = pwm_mode ? (cmp_m > cnt_m) : tog_q;
  end

  assign cnt = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      tog_q    <= 1'b0;
    end else begin
      if (clr)
        cnt_q <= '0;
      else if (tick)
        cnt_q <= (!pwm_mode && hit) ? '0 : step_count(cnt_q, top_v);
      if (clr || !pwm_mode || ovf_evt)
        shadow_q <= data;
      if (clr)
        tog_q <= 1'b0;
      else if (match_evt && !pwm_mode)
        tog_q <= ~tog_q;
    end
  end

  // R3
  pwm_no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pwm_mode && hit && !at_top && !clr) |=> (cnt_q != '0));
  // R7
  interval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pwm_mode && hit && !clr) |=> (cnt_q == '0));
  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !ovf_evt && !clr) |=> $stable(shadow_q));
  // R11
  counter_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int PSC_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] cnt_value,
  output logic       pwm_out,
  output logic       match_pend,
  output logic       ovf_pend,
  output logic       irq_match,
  output logic       irq_ovf
);
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_PSC  = 2'd2;

  logic             pwm_mode_q, match_ie_q, ovf_ie_q;
  res_e             res_q;
  logic [CNT_W-1:0] data_q;
  logic [PSC_W-1:0] psc_q;
  logic             wr_ctrl, clr, clr_match, clr_ovf;
  logic             tick, match_evt, ovf_evt;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign clr       = wr_ctrl && wr_data[3];
  assign clr_match = wr_ctrl && wr_data[6];
  assign clr_ovf   = wr_ctrl && wr_data[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_mode_q <= 1'b0;
      res_q      <= RES_8;
      match_ie_q <= 1'b0;
      ovf_ie_q   <= 1'b0;
      data_q     <= '0;
      psc_q      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          pwm_mode_q <= wr_data[0];
          res_q      <= res_e'(wr_data[2:1]);
          match_ie_q <= wr_data[4];
          ovf_ie_q   <= wr_data[5];
        end
        ADDR_DATA: data_q <= wr_data;
        ADDR_PSC:  psc_q  <= wr_data[PSC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_pend <= 1'b0;
      ovf_pend   <= 1'b0;
    end else begin
      if (match_evt)      match_pend <= 1'b1;
      else if (clr_match) match_pend <= 1'b0;
      if (ovf_evt)        ovf_pend   <= 1'b1;
      else if (clr_ovf)   ovf_pend   <= 1'b0;
    end
  end

  assign irq_match = match_pend & match_ie_q;
  assign irq_ovf   = ovf_pend & ovf_ie_q;

  pwmt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk (clk),
    .rst_n (rst_n),
    .clr (clr),
    .sel (psc_q),
    .tick (tick)
  );

  pwmt_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (clr),
    .pwm_mode  (pwm_mode_q),
    .res       (res_q),
    .data      (data_q),
    .cnt       (cnt_value),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .out       (pwm_out)
  );

  // R8
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> match_pend);
  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_pend);
  // R10
  match_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_match && !match_evt) |=> !match_pend);
  // R10
  ovf_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !ovf_evt) |=> !ovf_pend);
endmodule

// File: tb/tb_pwmt_top.sv
module tb_pwmt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_value;
  logic       pwm_out, match_pend, ovf_pend, irq_match, irq_ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pwmt_top dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .cnt_value (cnt_value), .pwm_out (pwm_out),
    .match_pend (match_pend), .ovf_pend (ovf_pend),
    .irq_match (irq_match), .irq_ovf (irq_ovf)
  );

  typedef struct packed {
    logic [1:0] res;
    logic [3:0] sel;
    logic [7:0] duty;
    int         high;
    int         period;
  } vec_t;

  // PWM table: expected high = (duty & top)*(sel+1), period = (top+1)*(sel+1)
  localparam vec_t VEC [7] = '{
    '{2'b00, 4'd0, 8'h80, 128, 256},
    '{2'b01, 4'd1, 8'h20, 64, 256},
    '{2'b10, 4'd2, 8'hFF, 189, 192},
    '{2'b00, 4'd0, 8'h00, 0, 256},
    '{2'b10, 4'd0, 8'h10, 16, 64},
    '{2'b00, 4'd3, 8'hFF, 1020, 1024},
    '{2'b11, 4'd0, 8'h40, 64, 256}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    while (cnt_value != v) @(negedge clk);
  endtask

  task automatic measure_period(output int n);
    do @(negedge clk); while (cnt_value == 8'h00);
    do @(negedge clk); while (cnt_value != 8'h00);
    n = 0;
    do begin @(negedge clk); n++; end while (cnt_value == 8'h00);
    do begin @(negedge clk); n++; end while (cnt_value != 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per, hi, tg;
    logic prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cnt_value == 0 && pwm_out == 0, "R1 cnt/out", int'(cnt_value), 0);
    chk(!match_pend && !ovf_pend && !irq_match && !irq_ovf, "R1 flags",
        int'({match_pend, ovf_pend, irq_match, irq_ovf}), 0);
    rst_n = 1'b1;

    // R3 R4 R5 R2 PWM table
    foreach (VEC[i]) begin
      wr(2'd2, {4'd0, VEC[i].sel});
      wr(2'd1, VEC[i].duty);
      wr(2'd0, 8'h09 | {5'd0, VEC[i].res, 1'b0});
      repeat (5) @(negedge clk);
      hi = 0;
      for (int k = 0; k < VEC[i].period; k++) begin
        @(negedge clk);
        if (pwm_out) hi++;
      end
      chk(hi == VEC[i].high, "R4 R5 high time", hi, VEC[i].high);
      measure_period(per);
      chk(per == VEC[i].period, "R3 R2 period", per, VEC[i].period);
    end

    // R6 shadow register: mid-period write waits for wrap
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h09);
    wait_cnt(8'h10);
    wr(2'd1, 8'h20);
    wait_cnt(8'h40);
    chk(pwm_out == 1'b1, "R6 old duty kept", int'(pwm_out), 1);
    wait_cnt(8'h00);
    wait_cnt(8'h40);
    chk(pwm_out == 1'b0, "R6 new duty at wrap", int'(pwm_out), 0);

    // R11 counter clear
    wait_cnt(8'h50);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h09;
    @(negedge clk);
    wr_en = 1'b0;
    chk(cnt_value == 8'h00, "R11 clear", int'(cnt_value), 0);

    // R7 interval mode, period and toggle
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd9);
    wr(2'd0, 8'h18);
    measure_period(per);
    chk(per == 10, "R7 interval period", per, 10);
    tg = 0;
    prev = pwm_out;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pwm_out != prev) tg++;
      prev = pwm_out;
    end
    chk(tg == 10, "R7 toggles", tg, 10);
    // R8 match flag and request
    chk(match_pend && irq_match, "R8 match pending", int'({match_pend, irq_match}), 3);
    // R10 write one to clear match flag
    wr(2'd0, 8'h58);
    chk(!match_pend && !irq_match, "R10 match clear", int'(match_pend), 0);
    // R2 R7 prescaled interval
    wr(2'd2, 8'h02);
    wr(2'd1, 8'd4);
    wr(2'd0, 8'h08);
    measure_period(per);
    chk(per == 15, "R2 R7 prescaled interval", per, 15);
    chk(match_pend && !irq_match, "R8 enable gate", int'({match_pend, irq_match}), 2);

    // R9 overflow flag, R10 clear, enable gate
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h2D);
    repeat (70) @(negedge clk);
    chk(ovf_pend && irq_ovf, "R9 overflow pending", int'({ovf_pend, irq_ovf}), 3);
    wr(2'd0, 8'h8D);
    chk(!ovf_pend && !irq_ovf, "R10 overflow clear", int'(ovf_pend), 0);
    repeat (70) @(negedge clk);
    chk(ovf_pend && !irq_ovf, "R9 enable gate", int'({ovf_pend, irq_ovf}), 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule